// File: doc/BRIEF.md
# Self-Clearing Capture Buffer with Framed Readout

This block captures a window of signed samples into on-chip storage and replays them later as a framed word stream. Software drives it through one control byte. Setting the top bit arms a capture. Setting the next bit requests a replay. Each of these two bits drops back to zero by itself when its operation completes, so software can poll the byte to learn when a capture has filled the store or when a replay has drained.

Samples arrive on a data-plus-strobe input and are written from the first location upward until the store is full. A replay sends a negative full-scale word first, then the stored samples in capture order, then a positive full-scale word. A downstream tool finds the frame edges from these two words. Output words move on a valid/ready handshake. A one-byte command input provides a second way to request a replay.

Top module: `capture_frame_buf`

## Requirements
- R1: The store holds DEPTH samples of DATA_W bits (defaults 6000 and 24). A capture writes one sample per cycle with `smp_valid` high, starting at location 0 and moving upward in arrival order.
- R2: Writing a control byte with bit 7 set starts a capture. Bit 7 reads 1 until the DEPTH-th sample is stored and then reads 0. Samples that arrive while no capture is running are not stored.
- R3: Writing bit 7 again during a capture restarts it at location 0, and the earlier partial capture is lost.
- R4: A replay starts when a control byte with bit 6 set is written, or when `cmd_code` 0x01 arrives with `cmd_valid`. Bit 6 reads 1 until the closing marker word has been accepted.
- R5: A replay frame is 0x800000 (in general, the MSB set and all other bits clear), then every stored sample in location order, then 0x7FFFFF (the MSB clear and all other bits set). After reset, before any capture, the frame is the two markers only.
- R6: A word advances only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_data` holds its value.
- R7: A replay requested while a capture is running waits until the capture completes. `out_valid` stays low throughout the capture.
- R8: Bits 5 and 4 of the control byte always read 0 and have no effect. Bits 3:0 are stored and read back. Writing 0 to bit 7 or bit 6 cancels nothing. Command codes other than 0x01 have no effect.
- R9: `busy` is high while a capture or a replay is in progress and low otherwise.
- R10: A bit 7 write that arrives while a replay is streaming is ignored. The replay continues with the samples that are already stored.
- R11: After reset the control byte reads 0x00, and both `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte write value |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code; 0x01 requests a replay |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed sample |
| out_ready | input | 1 | Downstream ready |
| ctrl_q | output | 8 | Control byte readback |
| busy | output | 1 | Capture or replay in progress |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Output word (marker or sample) |

## Verification
If the fill counter is wrong, the length of the next frame is wrong, and this shows at the closing marker of the first replay after the faulty capture. If the write pointer is wrong, samples come out shuffled or stale, and the mismatch appears at the first affected word after the opening marker. If a self-clearing bit is stuck, it shows in `ctrl_q` and `busy` one cycle after the event that should have cleared it. If the frame phase is wrong, a marker is missing or sits in the wrong place, and the first word of the frame shows it.

// File: rtl/capfb_pkg.sv
package capfb_pkg;
   typedef enum logic [1:0] {
      PH_HEAD = 2'd0,
      PH_BODY = 2'd1,
      PH_TAIL = 2'd2
   } frame_ph_t;

   localparam int unsigned CTRL_W  = 8;
   localparam int unsigned BIT_REC = 7;
   localparam int unsigned BIT_RD  = 6;
   localparam int unsigned LO_W    = 6;
   localparam logic [LO_W-1:0] LO_KEEP = 6'b00_1111;
   localparam logic [7:0] CMD_TX = 8'h01;
endpackage

// File: rtl/capfb_ctrl.sv
module capfb_ctrl
   import capfb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic              rec_done,
   input  logic              rd_done,
   output logic              rec_on,
   output logic              rd_on,
   output logic              rec_start,
   output logic [CTRL_W-1:0] ctrl_q
);
   logic            rec_q;
   logic            rd_q;
   logic [LO_W-1:0] lo_q;
   logic            rd_req;

   assign rd_req    = (ctrl_wr && ctrl_wdata[BIT_RD]) || (cmd_valid && (cmd_code == CMD_TX));
   assign rd_on     = rd_q && !rec_q;
   assign rec_on    = rec_q;
   assign rec_start = ctrl_wr && ctrl_wdata[BIT_REC] && !rd_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_q <= 1'b0;
         rd_q  <= 1'b0;
         lo_q  <= '0;
      end else begin
         if (ctrl_wr)
            lo_q <= ctrl_wdata[LO_W-1:0] & LO_KEEP;
         if (rec_start)
            rec_q <= 1'b1;
         else if (rec_done)
            rec_q <= 1'b0;
         if (rd_req)
            rd_q <= 1'b1;
         else if (rd_done)
            rd_q <= 1'b0;
      end
   end

   assign ctrl_q = {rec_q, rd_q, lo_q};
endmodule

// File: rtl/capfb_store.sv
module capfb_store #(
   parameter  int unsigned DATA_W = 24,
   parameter  int unsigned DEPTH  = 6000,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_on,
   input  logic              rec_start,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [CNT_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fill,
   output logic              rec_done
);
   localparam int unsigned ADDR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  fill_q;
   logic              wr_en;

   assign wr_en    = rec_on && smp_valid;
   assign rec_done = wr_en && (fill_q == CNT_W'(DEPTH - 1));
   assign fill     = fill_q;
   assign rd_data  = mem[rd_addr[ADDR_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fill_q <= '0;
      else if (rec_start)
         fill_q <= '0;
      else if (wr_en)
         fill_q <= fill_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[fill_q[ADDR_W-1:0]] <= smp_data;
   end
endmodule

// File: rtl/capfb_reader.sv
module capfb_reader
   import capfb_pkg::*;
#(
   parameter  int unsigned DATA_W = 24,
   parameter  int unsigned DEPTH  = 6000,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_on,
   input  logic [CNT_W-1:0]  fill,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [CNT_W-1:0]  rd_addr,
   output logic              rd_done
);
   localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};

   frame_ph_t        ph_q;
   logic [CNT_W-1:0] idx_q;
   logic             accept;

   assign out_valid = rd_on;
   assign accept    = rd_on && out_ready;
   assign rd_done   = accept && (ph_q == PH_TAIL);
   assign rd_addr   = idx_q;

   always_comb begin
      case (ph_q)
         PH_HEAD: out_data = NEG_FS;
         PH_BODY: out_data = rd_data;
         default: out_data = POS_FS;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_HEAD;
         idx_q <= '0;
      end else if (accept) begin
         case (ph_q)
            PH_HEAD: begin
               idx_q <= '0;
               ph_q  <= (fill == '0) ? PH_TAIL : PH_BODY;
            end
            PH_BODY: begin
               if (idx_q == fill - CNT_W'(1))
                  ph_q <= PH_TAIL;
               else
                  idx_q <= idx_q + CNT_W'(1);
            end
            default: begin
               ph_q  <= PH_HEAD;
               idx_q <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/capture_frame_buf.sv
module capture_frame_buf
   import capfb_pkg::*;
#(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned DEPTH  = 6000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [7:0]        ctrl_wdata,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              out_ready,
   output logic [7:0]        ctrl_q,
   output logic              busy,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("capture_frame_buf: DATA_W must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("capture_frame_buf: DEPTH must be at least 2");
   end

   logic              rec_on;
   logic              rd_on;
   logic              rec_start;
   logic              rec_done;
   logic              rd_done;
   logic [CNT_W-1:0]  fill;
   logic [CNT_W-1:0]  rd_addr;
   logic [DATA_W-1:0] rd_data;

   capfb_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .ctrl_wdata(ctrl_wdata),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .rec_done  (rec_done),
      .rd_done   (rd_done),
      .rec_on    (rec_on),
      .rd_on     (rd_on),
      .rec_start (rec_start),
      .ctrl_q    (ctrl_q)
   );

   capfb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rec_on   (rec_on),
      .rec_start(rec_start),
      .smp_valid(smp_valid),
      .smp_data (smp_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .fill     (fill),
      .rec_done (rec_done)
   );

   capfb_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_reader (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_on    (rd_on),
      .fill     (fill),
      .rd_data  (rd_data),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .out_data (out_data),
      .rd_addr  (rd_addr),
      .rd_done  (rd_done)
   );

   assign busy = rec_on | rd_on;
endmodule

// File: rtl/capfb_checker.sv
module capfb_checker #(
   parameter  int unsigned DATA_W = 24,
   parameter  int unsigned DEPTH  = 6000,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_rec,
   input logic              wr_rd,
   input logic              cmd_tx,
   input logic              rec_bit,
   input logic              rd_bit,
   input logic              busy,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              rec_done,
   input logic              rd_done,
   input logic [CNT_W-1:0]  fill
);
   localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH)); // R1
   AST_REC_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done && !wr_rec |=> !rec_bit); // R2
   AST_RD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done && !wr_rd && !cmd_tx |=> !rd_bit); // R4
   AST_FRAME_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_data == NEG_FS); // R5
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
   AST_NO_OUT_IN_REC: assert property (@(posedge clk) disable iff (!rst_n)
      rec_bit |-> !out_valid); // R7
   AST_BUSY_COVERS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy); // R9
   AST_REC_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !rec_bit); // R10
endmodule

bind capture_frame_buf capfb_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_rec   (ctrl_wr && ctrl_wdata[7]),
   .wr_rd    (ctrl_wr && ctrl_wdata[6]),
   .cmd_tx   (cmd_valid && (cmd_code == 8'h01)),
   .rec_bit  (ctrl_q[7]),
   .rd_bit   (ctrl_q[6]),
   .busy     (busy),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .rec_done (rec_done),
   .rd_done  (rd_done),
   .fill     (fill)
);

// File: tb/capture_frame_buf_test.sv
module capture_frame_buf_test;
   localparam int DW = 24;
   localparam int DP = 8;
   localparam logic [DW-1:0] NEG = 24'h800000;
   localparam logic [DW-1:0] POS = 24'h7FFFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_wr = 1'b0;
   logic [7:0]    ctrl_wdata = '0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_code = '0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          out_ready = 1'b0;
   logic [7:0]    ctrl_q;
   logic          busy;
   logic          out_valid;
   logic [DW-1:0] out_data;

   always #10 clk = ~clk;

   capture_frame_buf #(.DATA_W(DW), .DEPTH(DP)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .smp_valid(smp_valid),
      .smp_data(smp_data), .out_ready(out_ready), .ctrl_q(ctrl_q), .busy(busy),
      .out_valid(out_valid), .out_data(out_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [DW-1:0] model [DP];
   int mfill = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [DW-1:0] pat(int seed, int k);
      logic [31:0] v;
      v = 32'(seed) * 32'd40503 + 32'(k) * 32'd2654435 + 32'd17;
      return v[DW-1:0];
   endfunction

   task automatic wr_ctrl(logic [7:0] b);
      ctrl_wr = 1'b1; ctrl_wdata = b;
      @(negedge clk);
      ctrl_wr = 1'b0; ctrl_wdata = '0;
   endtask

   task automatic send_cmd(logic [7:0] c);
      cmd_valid = 1'b1; cmd_code = c;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = '0;
   endtask

   task automatic record(int seed, int first, int n, bit upd);
      for (int k = first; k < first + n; k++) begin
         logic [DW-1:0] v;
         v = pat(seed, k);
         smp_valid = 1'b1; smp_data = v;
         if (upd) begin
            if (mfill < DP) model[mfill] = v;
            mfill++;
         end
         @(negedge clk);
         smp_valid = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic drain(int mode, string req);
      int len;
      int got;
      int cyc;
      bit stalled;
      logic [DW-1:0] held;
      logic [DW-1:0] exp;
      len = ((mfill < DP) ? mfill : DP) + 2;
      got = 0; cyc = 0; stalled = 0; held = '0;
      while (got < len && cyc < 400) begin
         case (mode)
            0: out_ready = 1'b1;
            1: out_ready = cyc[0];
            default: out_ready = ((cyc % 3) == 2);
         endcase
         #1;
         if (stalled) chk("R6 stall hold", 32'(out_data), 32'(held));
         if (out_valid && out_ready) begin
            if (got == 0) exp = NEG;
            else if (got == len - 1) exp = POS;
            else exp = model[got - 1];
            chk({req, " R5 word"}, 32'(out_data), 32'(exp));
            got++;
         end
         stalled = out_valid && !out_ready;
         held = out_data;
         @(negedge clk);
         cyc++;
      end
      out_ready = 1'b0;
      #1;
      chk({req, " R5 frame length"}, 32'(got), 32'(len));
      chk("R4 bit6 self clear", 32'(ctrl_q[6]), 32'd0);
      chk("R9 busy low after replay", 32'(busy), 32'd0);
      chk("R6 no word after frame", 32'(out_valid), 32'd0);
   endtask

   initial begin
      #(20 * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 ctrl reset", 32'(ctrl_q), 32'h00);
      chk("R11 busy reset", 32'(busy), 32'd0);
      chk("R11 out_valid reset", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: empty store replay gives only the two markers
      mfill = 0;
      wr_ctrl(8'h40);
      chk("R9 busy during replay", 32'(busy), 32'd1);
      drain(0, "R5 empty");

      // R8: reserved bits and low nibble
      wr_ctrl(8'h3A);
      chk("R8 reserved bits read 0", 32'(ctrl_q), 32'h0A);
      chk("R8 reserved no busy", 32'(busy), 32'd0);
      chk("R8 reserved no output", 32'(out_valid), 32'd0);

      // R1 R2: capture with gaps, overrun ignored
      wr_ctrl(8'h85);
      mfill = 0;
      chk("R2 capture armed", 32'(ctrl_q), 32'h85);
      chk("R9 busy during capture", 32'(busy), 32'd1);
      record(1, 0, 5, 1);
      chk("R2 still capturing", 32'(ctrl_q[7]), 32'd1);
      wr_ctrl(8'h05);
      chk("R8 zero write cancels nothing", 32'(ctrl_q), 32'h85);
      record(1, 5, 3, 1);
      chk("R2 bit7 self clear", 32'(ctrl_q), 32'h05);
      chk("R9 busy low after capture", 32'(busy), 32'd0);
      record(7, 0, 3, 0);
      send_cmd(8'h02);
      chk("R8 other command ignored", 32'(out_valid), 32'd0);
      send_cmd(8'h01);
      chk("R4 command starts replay", 32'(ctrl_q[6]), 32'd1);
      drain(1, "R1 R4 cmd replay");
      wr_ctrl(8'h40);
      drain(2, "R1 bit6 replay");

      // R7: replay deferred during capture
      wr_ctrl(8'hC0);
      mfill = 0;
      chk("R7 both bits set", 32'(ctrl_q), 32'hC0);
      record(2, 0, 4, 1);
      chk("R7 no output in capture", 32'(out_valid), 32'd0);
      record(2, 4, 4, 1);
      chk("R7 replay follows capture", 32'(ctrl_q), 32'h40);
      chk("R7 output after capture", 32'(out_valid), 32'd1);
      drain(0, "R7 deferred");

      // R3: restart mid-capture
      wr_ctrl(8'h80);
      mfill = 0;
      record(3, 0, 3, 1);
      wr_ctrl(8'h80);
      mfill = 0;
      record(4, 0, 8, 1);
      chk("R3 restarted capture done", 32'(ctrl_q[7]), 32'd0);
      wr_ctrl(8'h40);
      drain(1, "R3 restart");

      // R10: capture request during replay ignored
      wr_ctrl(8'h40);
      wr_ctrl(8'h80);
      chk("R10 bit7 ignored in replay", 32'(ctrl_q), 32'h40);
      record(9, 0, 3, 0);
      drain(0, "R10 replay intact");

      // sweep seeds and ready patterns
      for (int s = 5; s < 11; s++) begin
         wr_ctrl(8'h80);
         mfill = 0;
         record(s, 0, DP, 1);
         chk("R2 sweep bit7 clear", 32'(ctrl_q[7]), 32'd0);
         wr_ctrl(8'h40);
         drain(s % 3, "R1 sweep");
      end

      report();
   end
endmodule